// File: doc/BRIEF.md
# Baud Tick Generator

This block turns the CPU bus clock into the two timing strobes that an asynchronous serial transmitter and receiver need. It has a 16x oversampling strobe and a once-per-bit strobe. The rate comes from a byte-wide configuration register with two divider fields. A prescaler field picks one of four ratios: 1, 3, 4 or 13. A rate field then multiplies that ratio by a power of two, from 1 up to 128. The oversampling strobe therefore repeats every `ratio × 2^rate` bus cycles. The bit strobe fires on every sixteenth oversampling strobe. With a bus clock of a quarter of the crystal frequency, the line rate is `(fosc/4) / (ratio × 16 × 2^rate)`.

Software programs the divider by writing the register. Every write restarts all counters, so the new rate takes effect from a clean phase. An ordinary reset loads the slowest-to-fastest neutral setting, which is divide-by-1 at rate 0. If the boot-mode input is high during reset, the register is preloaded with 0x33 instead. That value selects ratio 13 and rate 3, which is 1200 baud from a 2 MHz bus clock.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst_n` is low with `boot_mode` low, `cfg_q` is 0x00. In that setting `os_tick` is high in every cycle.
- R2: While `rst_n` is low with `boot_mode` high, `cfg_q` is 0x33. After release, successive `os_tick` pulses are 104 cycles apart.
- R3: Bits 5:4 of the configuration select the prescale ratio: 00 gives 1, 01 gives 3, 10 gives 4, 11 gives 13.
- R4: Bits 2:0 of the configuration hold a rate value r. The `os_tick` period becomes the prescale ratio × 2^r bus cycles, with r from 0 to 7.
- R5: `os_tick` pulses last one cycle when the period N is greater than 1. Consecutive pulses are exactly N cycles apart.
- R6: `bit_tick` is high only together with `os_tick`, on every sixteenth `os_tick` after a restart. Exactly 16 `os_tick` pulses occur up to and including the first `bit_tick`.
- R7: A cycle with `wr_en` high stores `wr_data` as a whole, and `cfg_q` shows it from the next cycle. Bits 7:6 and 3 read back as written but do not change the timing.
- R8: A write restarts every counter, including one in the middle of a period. Count the cycle after the write edge as cycle 1. The first `os_tick` then appears in cycle N and the first `bit_tick` in cycle 16·N.
- R9: Without `wr_en`, `cfg_q` holds its value whatever `wr_data` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, divider input |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_mode | input | 1 | Selects the boot preload (0x33) for the register during reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 8 | Configuration value to store |
| cfg_q | output | 8 | Current configuration register contents |
| os_tick | output | 1 | 16x oversampling strobe, one cycle wide |
| bit_tick | output | 1 | One strobe per serial bit time |

## Verification
The outputs are combinational decodes of the counter registers. After a write at edge k, the register readback changes in the cycle that follows. The first oversampling strobe is due N cycles after that edge, and the first bit strobe 16·N cycles after it. The bench drives inputs on falling edges and counts falling edges from the write. Each of these three results is compared against that exact cycle number, and the gap to the second strobe is checked against N. A boot-mode reset hides the phase at release, so for that case only the spacing between two strobes is compared.

// File: rtl/baud_pkg.sv
package baud_pkg;

    localparam int PRE_SEL_W = 2;

    // Prescale ratio for each select code
    function automatic int unsigned pre_ratio(input logic [PRE_SEL_W-1:0] sel);
        int unsigned r;
        unique case (sel)
            2'b00: r = 1;
            2'b01: r = 3;
            2'b10: r = 4;
            2'b11: r = 13;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/baud_presc.sv
module baud_presc
    import baud_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart,
    input  logic [PRE_SEL_W-1:0] sel,
    output logic                 hit
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    always_comb begin
        last = CNT_W'(pre_ratio(sel) - 1);
        hit  = (cnt == last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (restart) cnt <= '0;
        else if (hit)     cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/baud_pow2.sv
module baud_pow2 #(
    parameter int RATE_W = 3,
    parameter int CNT_W  = (1 << RATE_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    input  logic [RATE_W-1:0] rate,
    output logic              hit
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mask;

    always_comb begin
        mask = ~({CNT_W{1'b1}} << rate);
        hit  = step && (cnt == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (restart) cnt <= '0;
        else if (hit)     cnt <= '0;
        else if (step)    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/baud_os.sv
module baud_os #(
    parameter int OS_FACTOR = 16,
    localparam int OS_W     = $clog2(OS_FACTOR)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic step,
    output logic hit
);
    logic [OS_W-1:0] cnt;

    always_comb hit = step && (cnt == OS_W'(OS_FACTOR - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (restart) cnt <= '0;
        else if (hit)     cnt <= '0;
        else if (step)    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int          CFG_W     = 8,
    parameter int          PRE_LSB   = 4,
    parameter int          RATE_W    = 3,
    parameter int          OS_FACTOR = 16,
    parameter logic [7:0]  RST_CFG   = 8'h00,
    parameter logic [7:0]  BOOT_CFG  = 8'h33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boot_mode,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] cfg_q,
    output logic             os_tick,
    output logic             bit_tick
);
    localparam int PRE_CNT_W  = 4;
    localparam int RATE_CNT_W = (1 << RATE_W) - 1;

    logic [CFG_W-1:0] cfg_r;
    logic             pre_hit;
    logic             rate_hit;
    logic             bit_hit;

    // Configuration register; boot strap chooses the reset value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cfg_r <= boot_mode ? CFG_W'(BOOT_CFG) : CFG_W'(RST_CFG);
        else if (wr_en) cfg_r <= wr_data;
    end

    baud_presc #(.CNT_W(PRE_CNT_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_en),
        .sel     (cfg_r[PRE_LSB +: PRE_SEL_W]),
        .hit     (pre_hit)
    );

    baud_pow2 #(.RATE_W(RATE_W), .CNT_W(RATE_CNT_W)) u_pow2 (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_en),
        .step    (pre_hit),
        .rate    (cfg_r[RATE_W-1:0]),
        .hit     (rate_hit)
    );

    baud_os #(.OS_FACTOR(OS_FACTOR)) u_os (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_en),
        .step    (rate_hit),
        .hit     (bit_hit)
    );

    always_comb begin
        cfg_q    = cfg_r;
        os_tick  = rate_hit;
        bit_tick = bit_hit;
    end
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk
    import baud_pkg::*;
#(
    parameter int CFG_W     = 8,
    parameter int PRE_LSB   = 4,
    parameter int RATE_W    = 3,
    parameter int OS_FACTOR = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [CFG_W-1:0] wr_data,
    input logic [CFG_W-1:0] cfg_q,
    input logic             os_tick,
    input logic             bit_tick
);
    int unsigned period;
    int unsigned gap;
    int unsigned os_seen;

    always_comb period = pre_ratio(cfg_q[PRE_LSB +: PRE_SEL_W]) << cfg_q[RATE_W-1:0];

    // Cycles since the last restart or oversampling strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 gap <= 1;
        else if (wr_en || os_tick)  gap <= 1;
        else if (gap < 32'hFFFF)    gap <= gap + 1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        os_seen <= 0;
        else if (wr_en)    os_seen <= 0;
        else if (bit_tick) os_seen <= 0;
        else if (os_tick)  os_seen <= os_seen + 1;
    end

    // R5
    os_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        os_tick |-> gap == period);

    // R8
    os_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gap == period) |-> os_tick);

    // R6
    bit_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);

    // R6
    bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_seen == OS_FACTOR - 1);

    // R7
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cfg_q == $past(wr_data));

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q));
endmodule

bind baud_tick_gen baud_tick_gen_chk #(
    .CFG_W(CFG_W), .PRE_LSB(PRE_LSB), .RATE_W(RATE_W), .OS_FACTOR(OS_FACTOR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .cfg_q    (cfg_q),
    .os_tick  (os_tick),
    .bit_tick (bit_tick)
);

// File: tb/tb_baud_tick_gen.sv
`timescale 1ns/1ps
module tb_baud_tick_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       boot_mode = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] cfg_q;
    logic       os_tick;
    logic       bit_tick;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    baud_tick_gen dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot_mode (boot_mode),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .cfg_q     (cfg_q),
        .os_tick   (os_tick),
        .bit_tick  (bit_tick)
    );

    // Configuration and hand-worked period N = ratio * 2^rate
    localparam int NV = 11;
    localparam logic [7:0] V_CFG [0:NV-1] =
        '{8'h00, 8'h10, 8'h20, 8'h30, 8'h01, 8'h12, 8'h23, 8'h37, 8'h05, 8'hC8, 8'h4B};
    localparam int V_N [0:NV-1] =
        '{1, 3, 4, 13, 2, 12, 32, 1664, 32, 1, 8};

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic boot);
        @(negedge clk);
        boot_mode = boot;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Write cfg, then count cycles (cycle 1 = the one after the write edge)
    task automatic run_vec(input logic [7:0] cfg, input int n, input string req);
        int first_os = 0;
        int second_os = 0;
        int first_bit = 0;
        int os_cnt = 0;
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = cfg;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = ~cfg;
        check("R7", "cfg readback", int'(cfg_q), int'(cfg));
        for (int j = 1; j <= 16 * n + 2; j++) begin
            if (j > 1) @(negedge clk);
            if (os_tick) begin
                os_cnt++;
                if (first_os == 0) first_os = j;
                else if (second_os == 0) second_os = j;
            end
            if (bit_tick && first_bit == 0) first_bit = j;
            if (first_bit != 0) break;
        end
        check(req, "first os_tick cycle (R8)", first_os, n);
        check("R5", "second os_tick cycle", second_os, 2 * n);
        check("R6", "first bit_tick cycle", first_bit, 16 * n);
        check("R6", "os_tick pulses up to bit_tick", os_cnt, 16);
    endtask

    initial begin
        #(5.0 * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int t1;
        int t2;
        // R1: plain reset default
        do_reset(1'b0);
        @(negedge clk);
        check("R1", "reset cfg", int'(cfg_q), 0);
        check("R1", "os_tick at divide-by-1", int'(os_tick), 1);
        @(negedge clk);
        check("R1", "os_tick next cycle", int'(os_tick), 1);

        // Table walk: R3 prescale, R4 rate, R7 ignored bits
        for (int i = 0; i < NV; i++) begin
            if (i < 4)       run_vec(V_CFG[i], V_N[i], "R3");
            else if (i < 9)  run_vec(V_CFG[i], V_N[i], "R4");
            else             run_vec(V_CFG[i], V_N[i], "R7");
        end

        // R8: rewrite in the middle of a period
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = 8'h30;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (6) @(negedge clk);
        run_vec(8'h30, 13, "R8");

        // R9: wr_data moves without a strobe
        wr_data = 8'hFF;
        repeat (20) @(negedge clk);
        wr_data = 8'h00;
        repeat (5) @(negedge clk);
        check("R9", "cfg held without write", int'(cfg_q), 8'h30);

        // R2: boot-mode preload
        do_reset(1'b1);
        check("R2", "boot cfg", int'(cfg_q), 8'h33);
        t1 = 0;
        t2 = 0;
        for (int j = 1; j <= 400; j++) begin
            @(negedge clk);
            if (os_tick) begin
                if (t1 == 0) t1 = j;
                else if (t2 == 0) t2 = j;
            end
            if (t2 != 0) break;
        end
        check("R2", "boot os_tick spacing", t2 - t1, 104);
        boot_mode = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule